// File: doc/BRIEF.md
# Spread-Spectrum Modulation Profile Generator

This block produces the digital triangular profile that steers a downstream fractional divider or PLL when it spreads a clock. It runs on the reference clock. Each output word is a signed frequency offset in tenths of a percent. Three ternary selects set the profile, and each arrives already resolved into a low, middle or high code. Two selects pick the spread style and its depth. A third select picks the input frequency range, and the range sets how many reference cycles one modulation period lasts. A two-bit sub-band index gives the quarter of that range the reference falls in. Higher quarters get slightly smaller deviations.

One modulation period starts at the minimum-frequency point, climbs to the maximum and comes back down. The rise and the fall each take half the period. The offset moves by at most one tenth of a percent per reference cycle, and an accumulator keeps both end points exact. A one-cycle strobe marks the start of each period. The selects are sampled only at that boundary, so a change in the middle of a period never distorts the triangle that is under way.

Top module: `ssc_profile_gen`

## Requirements
- R1: While rst_ni is low, offset_o is 0, period_o is 0 and mode_o is 0 (no spread).
- R2: A period lasts 128 cycles when rng_i is low, 256 when it is high and 512 when it is middle. The codes are 2'b00 low, 2'b01 middle and 2'b10 high.
- R3: Let N be the period length, H = N/2, lo the minimum offset, hi the maximum offset and span = hi - lo. At phase p of a period, the offset is lo + floor(span*p/H) for p <= H, and hi - floor(span*(p-H)/H) for p > H.
- R4: Center spread swings between -A and +A. The (sel_hi_i, sel_lo_i) pairs (0,0), (0,M), (0,1) and (M,0) select depth levels 0 to 3. In sub-band 0 these give A = 14, 12, 6 and 5.
- R5: Down spread swings between -A and 0. The pairs (1,1), (1,0), (M,1) and (1,M) select depth levels 0 to 3. In sub-band 0 these give A = 30, 22, 19 and 7.
- R6: The pair (M,M) selects no spread, and offset_o stays at 0 for the whole period.
- R7: Sub-bands 1, 2 and 3 give these center depths for levels 0 to 3: 13/11/5/4, 12/9/5/4 and 11/9/4/3. They give these down depths: 27/19/17/6, 25/18/15/6 and 23/17/14/5.
- R8: period_o is high for exactly one cycle per period, in phase 0, which is the first cycle after reset release and the cycle after each period's last cycle. In that cycle offset_o equals the minimum offset.
- R9: All selects, including band_i, are sampled only at the clock edge that starts a period. A change at any other time does not alter the running period.
- R10: The unused code 2'b11 on any select acts as middle.
- R11: Between consecutive cycles of one period, offset_o changes by at most 1.
- R12: mode_o reports the latched style: 0 for none, 1 for center, 2 for down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_hi_i | input | 2 | First style/depth select, ternary code |
| sel_lo_i | input | 2 | Second style/depth select, ternary code |
| rng_i | input | 2 | Input frequency range select, ternary code |
| band_i | input | 2 | Sub-band of the reference within the range |
| offset_o | output | 8 | Signed frequency offset, 0.1 % units |
| period_o | output | 1 | Strobe at the start (minimum point) of each period |
| mode_o | output | 2 | Latched spread style |

## Verification
The assertions assume that the selects and the band index do not glitch across the sampling edge, so that the value taken at a period boundary is well defined. The step and range properties also rely on the depth tables keeping every swing below half the shortest period, so that the accumulator never owes more than one step in a cycle. The stimulus changes inputs only on the falling clock edge. It moves to the next configuration a quarter of the way into each period, which puts every select change well away from the sampling edge. The sweep covers every code of every select, the unused code included, together with every sub-band.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

  typedef enum logic [1:0] {
    TL_LOW  = 2'b00,
    TL_MID  = 2'b01,
    TL_HIGH = 2'b10
  } tlev_e;

  typedef enum logic [1:0] {
    SPR_NONE   = 2'd0,
    SPR_CENTER = 2'd1,
    SPR_DOWN   = 2'd2
  } spread_e;

  typedef struct packed {
    spread_e    mode;
    logic [1:0] lvl;   // 0 = deepest
    logic [1:0] rsh;   // range shift: 0 -> x1, 1 -> x2, 2 -> x4
  } sel_cfg_t;

  // unused code folds to middle (R10)
  function automatic tlev_e tern_fold(input logic [1:0] code);
    case (code)
      2'b00:   return TL_LOW;
      2'b10:   return TL_HIGH;
      default: return TL_MID;
    endcase
  endfunction

endpackage

// File: rtl/ssc_sel_decode.sv
module ssc_sel_decode
  import ssc_pkg::*;
(
  input  logic [1:0] sel_hi_i,
  input  logic [1:0] sel_lo_i,
  input  logic [1:0] rng_i,
  output sel_cfg_t   cfg_o
);

  tlev_e a, b, r;

  always_comb begin
    a = tern_fold(sel_hi_i);
    b = tern_fold(sel_lo_i);
    r = tern_fold(rng_i);

    cfg_o.mode = SPR_NONE;
    cfg_o.lvl  = 2'd0;
    if (a == TL_LOW && b == TL_LOW) begin
      cfg_o.mode = SPR_CENTER; cfg_o.lvl = 2'd0;
    end else if (a == TL_LOW && b == TL_MID) begin
      cfg_o.mode = SPR_CENTER; cfg_o.lvl = 2'd1;
    end else if (a == TL_LOW && b == TL_HIGH) begin
      cfg_o.mode = SPR_CENTER; cfg_o.lvl = 2'd2;
    end else if (a == TL_MID && b == TL_LOW) begin
      cfg_o.mode = SPR_CENTER; cfg_o.lvl = 2'd3;
    end else if (a == TL_HIGH && b == TL_HIGH) begin
      cfg_o.mode = SPR_DOWN; cfg_o.lvl = 2'd0;
    end else if (a == TL_HIGH && b == TL_LOW) begin
      cfg_o.mode = SPR_DOWN; cfg_o.lvl = 2'd1;
    end else if (a == TL_MID && b == TL_HIGH) begin
      cfg_o.mode = SPR_DOWN; cfg_o.lvl = 2'd2;
    end else if (a == TL_HIGH && b == TL_MID) begin
      cfg_o.mode = SPR_DOWN; cfg_o.lvl = 2'd3;
    end

    case (r)
      TL_LOW:  cfg_o.rsh = 2'd0;
      TL_HIGH: cfg_o.rsh = 2'd1;
      default: cfg_o.rsh = 2'd2;
    endcase
  end

endmodule

// File: rtl/ssc_amp_rom.sv
module ssc_amp_rom
  import ssc_pkg::*;
#(
  parameter int AMP_W = 6
) (
  input  spread_e          mode_i,
  input  logic [1:0]       lvl_i,
  input  logic [1:0]       band_i,
  output logic [AMP_W-1:0] amp_o
);

  logic [3:0] idx;
  assign idx = {band_i, lvl_i};

  function automatic logic [AMP_W-1:0] ctr_amp(input logic [3:0] i);
    case (i)
      4'h0: return AMP_W'(14);
      4'h1: return AMP_W'(12);
      4'h2: return AMP_W'(6);
      4'h3: return AMP_W'(5);
      4'h4: return AMP_W'(13);
      4'h5: return AMP_W'(11);
      4'h6: return AMP_W'(5);
      4'h7: return AMP_W'(4);
      4'h8: return AMP_W'(12);
      4'h9: return AMP_W'(9);
      4'hA: return AMP_W'(5);
      4'hB: return AMP_W'(4);
      4'hC: return AMP_W'(11);
      4'hD: return AMP_W'(9);
      4'hE: return AMP_W'(4);
      default: return AMP_W'(3);
    endcase
  endfunction

  function automatic logic [AMP_W-1:0] dn_amp(input logic [3:0] i);
    case (i)
      4'h0: return AMP_W'(30);
      4'h1: return AMP_W'(22);
      4'h2: return AMP_W'(19);
      4'h3: return AMP_W'(7);
      4'h4: return AMP_W'(27);
      4'h5: return AMP_W'(19);
      4'h6: return AMP_W'(17);
      4'h7: return AMP_W'(6);
      4'h8: return AMP_W'(25);
      4'h9: return AMP_W'(18);
      4'hA: return AMP_W'(15);
      4'hB: return AMP_W'(6);
      4'hC: return AMP_W'(23);
      4'hD: return AMP_W'(17);
      4'hE: return AMP_W'(14);
      default: return AMP_W'(5);
    endcase
  endfunction

  always_comb begin
    case (mode_i)
      SPR_CENTER: amp_o = ctr_amp(idx);
      SPR_DOWN:   amp_o = dn_amp(idx);
      default:    amp_o = '0;
    endcase
  end

endmodule

// File: rtl/ssc_tri_core.sv
module ssc_tri_core #(
  parameter int PH_W  = 9,
  parameter int AMP_W = 6,
  parameter int OFF_W = 8,
  parameter int ACC_W = PH_W + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  logic signed [OFF_W-1:0] lo_ld_i,
  input  logic [AMP_W:0]          span_i,
  input  logic [PH_W-1:0]         half_i,
  output logic [PH_W-1:0]         phase_o,
  output logic                    wrap_o,
  output logic signed [OFF_W-1:0] val_o
);

  logic [PH_W-1:0]         ph_q;
  logic [ACC_W-1:0]        acc_q;
  logic signed [OFF_W-1:0] val_q;
  logic [ACC_W-1:0]        sum;
  logic [PH_W:0]           dr_full;
  logic                    rising;
  logic                    carry;

  assign dr_full = {half_i, 1'b0};
  assign wrap_o  = ({1'b0, ph_q} == (dr_full - 1'b1));
  assign rising  = (ph_q < half_i);
  assign sum     = acc_q + ACC_W'(span_i);
  assign carry   = (sum >= ACC_W'(half_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= '0;
      acc_q <= '0;
      val_q <= '0;
    end else if (load_i) begin
      ph_q  <= '0;
      acc_q <= '0;
      val_q <= lo_ld_i;
    end else begin
      ph_q <= ph_q + 1'b1;
      if (carry) begin
        acc_q <= sum - ACC_W'(half_i);
        val_q <= rising ? val_q + OFF_W'(1) : val_q - OFF_W'(1);
      end else begin
        acc_q <= sum;
      end
    end
  end

  assign phase_o = ph_q;
  assign val_o   = val_q;

endmodule

// File: rtl/ssc_profile_gen.sv
module ssc_profile_gen
  import ssc_pkg::*;
#(
  parameter int BASE_LOG2 = 7,
  parameter int OFF_W     = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [1:0]              sel_hi_i,
  input  logic [1:0]              sel_lo_i,
  input  logic [1:0]              rng_i,
  input  logic [1:0]              band_i,
  output logic signed [OFF_W-1:0] offset_o,
  output logic                    period_o,
  output logic [1:0]              mode_o
);

  localparam int PH_W  = BASE_LOG2 + 2;
  localparam int AMP_W = OFF_W - 2;
  localparam int ACC_W = PH_W + 1;

  sel_cfg_t         cfg_nxt;
  logic [AMP_W-1:0] amp_nxt;

  spread_e          mode_q;
  logic [AMP_W-1:0] amp_q;
  logic [1:0]       rsh_q;
  logic             running_q;

  logic                    load;
  logic                    wrap;
  logic [PH_W-1:0]         phase;
  logic [PH_W-1:0]         half_cur;
  logic [AMP_W:0]          span_cur;
  logic signed [OFF_W-1:0] lo_ld;
  logic signed [OFF_W-1:0] val;

  ssc_sel_decode u_dec (
    .sel_hi_i (sel_hi_i),
    .sel_lo_i (sel_lo_i),
    .rng_i    (rng_i),
    .cfg_o    (cfg_nxt)
  );

  ssc_amp_rom #(.AMP_W(AMP_W)) u_rom (
    .mode_i (cfg_nxt.mode),
    .lvl_i  (cfg_nxt.lvl),
    .band_i (band_i),
    .amp_o  (amp_nxt)
  );

  // selects are taken only when a period starts (R9)
  assign load = !running_q || wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= SPR_NONE;
      amp_q     <= '0;
      rsh_q     <= '0;
      running_q <= 1'b0;
    end else if (load) begin
      mode_q    <= cfg_nxt.mode;
      amp_q     <= amp_nxt;
      rsh_q     <= cfg_nxt.rsh;
      running_q <= 1'b1;
    end
  end

  assign lo_ld    = OFF_W'(0) - OFF_W'(amp_nxt);
  assign half_cur = PH_W'(1) << (BASE_LOG2 - 1 + int'(rsh_q));

  always_comb begin
    case (mode_q)
      SPR_CENTER: span_cur = {amp_q, 1'b0};
      SPR_DOWN:   span_cur = {1'b0, amp_q};
      default:    span_cur = '0;
    endcase
  end

  ssc_tri_core #(
    .PH_W  (PH_W),
    .AMP_W (AMP_W),
    .OFF_W (OFF_W),
    .ACC_W (ACC_W)
  ) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .lo_ld_i (lo_ld),
    .span_i  (span_cur),
    .half_i  (half_cur),
    .phase_o (phase),
    .wrap_o  (wrap),
    .val_o   (val)
  );

  assign offset_o = val;
  assign period_o = running_q && (phase == '0);
  assign mode_o   = mode_q;

endmodule

// File: rtl/ssc_profile_chk.sv
module ssc_profile_chk #(
  parameter int OFF_W = 8,
  parameter int PH_W  = 9,
  parameter int AMP_W = 6
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic signed [OFF_W-1:0] offset_i,
  input logic                    period_i,
  input logic [1:0]              mode_i,
  input logic                    running_i,
  input logic [AMP_W-1:0]        amp_i,
  input logic [PH_W-1:0]         phase_i,
  input logic [PH_W-1:0]         half_i
);

  logic signed [OFF_W-1:0] neg_amp, pos_amp, prev_q, diff;
  logic [PH_W:0]           cnt_q, drs_q;
  logic                    seen_q;

  assign neg_amp = OFF_W'(0) - OFF_W'(amp_i);
  assign pos_amp = OFF_W'(amp_i);
  assign diff    = offset_i - prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      cnt_q  <= '0;
      drs_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      prev_q <= offset_i;
      if (period_i) begin
        cnt_q  <= (PH_W+1)'(1);
        drs_q  <= {half_i, 1'b0};
        seen_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_PERIOD_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_i && seen_q |-> cnt_q == drs_q); // R2
  AST_PEAK_EXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running_i && phase_i == half_i |-> offset_i == (mode_i == 2'd1 ? pos_amp : OFF_W'(0))); // R3
  AST_CENTER_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'd1 |-> offset_i >= neg_amp && offset_i <= pos_amp); // R4
  AST_DOWN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'd2 |-> offset_i >= neg_amp && offset_i <= 0); // R5
  AST_NONE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'd0 |-> offset_i == 0); // R6
  AST_STROBE_AT_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_i |-> offset_i == neg_amp); // R8
  AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_i |=> !period_i); // R8
  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running_i && !period_i |-> $stable(mode_i)); // R9
  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running_i && !period_i |-> diff >= -1 && diff <= 1); // R11
  AST_MODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i != 2'd3); // R12

endmodule

bind ssc_profile_gen ssc_profile_chk #(
  .OFF_W (OFF_W),
  .PH_W  (PH_W),
  .AMP_W (AMP_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .offset_i  (offset_o),
  .period_i  (period_o),
  .mode_i    (mode_o),
  .running_i (running_q),
  .amp_i     (amp_q),
  .phase_i   (phase),
  .half_i    (half_cur)
);

// File: tb/ssc_profile_gen_bench.sv
module ssc_profile_gen_bench;

  logic              clk_i = 1'b0;
  logic              rst_ni;
  logic [1:0]        sel_hi_i, sel_lo_i, rng_i, band_i;
  logic signed [7:0] offset_o;
  logic              period_o;
  logic [1:0]        mode_o;

  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;

  ssc_profile_gen u_ssc_profile_gen (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_hi_i (sel_hi_i),
    .sel_lo_i (sel_lo_i),
    .rng_i    (rng_i),
    .band_i   (band_i),
    .offset_o (offset_o),
    .period_o (period_o),
    .mode_o   (mode_o)
  );

  int ctab [4][4] = '{'{14, 12, 6, 5}, '{13, 11, 5, 4}, '{12, 9, 5, 4}, '{11, 9, 4, 3}};
  int dtab [4][4] = '{'{30, 22, 19, 7}, '{27, 19, 17, 6}, '{25, 18, 15, 6}, '{23, 17, 14, 5}};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // 0 low, 1 middle, 2 high; 2'b11 folds to middle (R10)
  function automatic int lvl3(input logic [1:0] c);
    if (c == 2'b00) return 0;
    if (c == 2'b10) return 2;
    return 1;
  endfunction

  task automatic apply(input int idx);
    logic [7:0] v;
    v = idx[7:0];
    sel_hi_i = v[7:6];
    sel_lo_i = v[5:4];
    rng_i    = v[3:2];
    band_i   = v[1:0];
  endtask

  task automatic expect_cfg(input int idx, output int mode, output int amp, output int dr);
    logic [7:0] v;
    int a, b, r, bd, lv;
    v  = idx[7:0];
    a  = lvl3(v[7:6]);
    b  = lvl3(v[5:4]);
    r  = lvl3(v[3:2]);
    bd = int'(v[1:0]);
    mode = 0; lv = 0;
    if      (a == 0 && b == 0) begin mode = 1; lv = 0; end
    else if (a == 0 && b == 1) begin mode = 1; lv = 1; end
    else if (a == 0 && b == 2) begin mode = 1; lv = 2; end
    else if (a == 1 && b == 0) begin mode = 1; lv = 3; end
    else if (a == 2 && b == 2) begin mode = 2; lv = 0; end
    else if (a == 2 && b == 0) begin mode = 2; lv = 1; end
    else if (a == 1 && b == 2) begin mode = 2; lv = 2; end
    else if (a == 2 && b == 1) begin mode = 2; lv = 3; end
    amp = (mode == 1) ? ctab[bd][lv] : (mode == 2) ? dtab[bd][lv] : 0;
    dr  = (r == 0) ? 128 : (r == 2) ? 256 : 512;
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    errors++;
    $display("FAIL R2 watchdog expired actual 1 expected 0");
    finish_run();
  end

  initial begin
    int mode, amp, dr, lo, hi, span, h, exp_off, prev;
    logic [7:0] v;
    string tag;
    apply(0);
    rst_ni = 1'b0;
    #3;
    chk(offset_o == 0, "R1 offset in reset", int'(offset_o), 0);
    chk(period_o == 1'b0, "R1 strobe in reset", int'(period_o), 0);
    chk(mode_o == 2'd0, "R1 mode in reset", int'(mode_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int idx = 0; idx < 256; idx++) begin
      expect_cfg(idx, mode, amp, dr);
      v    = idx[7:0];
      h    = dr / 2;
      lo   = -amp;
      hi   = (mode == 1) ? amp : 0;
      span = hi - lo;
      tag  = (mode == 1) ? "R4" : (mode == 2) ? "R5" : "R6";
      if (v[1:0] != 2'b00) tag = {tag, "/R7"};
      if (v[7:6] == 2'b11 || v[5:4] == 2'b11 || v[3:2] == 2'b11) tag = {tag, "/R10"};
      prev = 0;
      for (int p = 0; p < dr; p++) begin
        string t2;
        exp_off = (p <= h) ? lo + (span * p) / h : hi - (span * (p - h)) / h;
        t2 = (p > dr / 4) ? {"R3/R9/", tag} : {"R3/", tag};
        chk(int'(offset_o) == exp_off, $sformatf("%s offset cfg %0d phase %0d", t2, idx, p),
            int'(offset_o), exp_off);
        chk(period_o == (p == 0), $sformatf("%s strobe cfg %0d phase %0d",
            (p == 0) ? "R8" : "R2", idx, p), int'(period_o), int'(p == 0));
        chk(int'(mode_o) == mode, $sformatf("R12/R9 mode cfg %0d phase %0d", idx, p),
            int'(mode_o), mode);
        if (p > 0) begin
          chk((int'(offset_o) - prev) <= 1 && (int'(offset_o) - prev) >= -1,
              $sformatf("R11 step cfg %0d phase %0d", idx, p), int'(offset_o) - prev, 1);
        end
        prev = int'(offset_o);
        if (p == dr / 4 && idx < 255) apply(idx + 1);
        @(negedge clk_i);
      end
    end
    finish_run();
  end

endmodule